// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit register-machine CPU. Each cycle it receives a 16-bit instruction word, the current values of the destination operand and the source operand as read from the register file, and the current status byte. It decodes the word itself and works out three things: which register indices the word names, the 8-bit result and whether that result is to be written back, and the new status byte. The result covers add and subtract, with and without carry, compares, the bitwise operations, complement, negate, increment, decrement, the shift and rotate group, nibble exchange and immediate load.

The block has no storage. Words arrive on a valid/ready stream and leave on a valid/ready stream in the same cycle. `out_valid` follows `in_valid`. `in_ready` follows `out_ready`, so back-pressure from the consumer reaches the producer unchanged. A word moves through on a cycle in which `in_valid` and `out_ready` are both high. The producer must hold `in_insn`, `in_rd`, `in_rr` and `in_flags` steady while it waits.

The index outputs depend only on the instruction word. The register file can therefore read through them and feed `in_rd` and `in_rr` back within the same cycle.

Top module: `byte_alu`

## Requirements
- R1: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in every cycle. `out_wr_en` is high only while `in_valid` is high. The outputs settle within the cycle in which the inputs are presented.
- R2: The status byte places its bits at fixed positions: C bit 0, Z bit 1, N bit 2, V bit 3, S bit 4, H bit 5, T bit 6, I bit 7. T and I always pass from `in_flags` to `out_flags` unchanged.
- R3: Register-register words select the operation with bits 15:10: ADD 000011, ADC 000111, SUB 000110, SBC 000010, CPC 000001, CP 000101, AND 001000, EOR 001001, OR 001010. The destination index is bits 8:4 and the source index is {bit 9, bits 3:0}. ADD computes Rd+Rr, ADC computes Rd+Rr+C, SUB computes Rd-Rr and SBC computes Rd-Rr-C, all modulo 256.
- R4: Immediate words select the operation with bits 15:12: CPI 0011, SBCI 0100, SUBI 0101, ORI 0110, ANDI 0111, LDI 1110. The constant is {bits 11:8, bits 3:0}. The destination index (also driven on `src_idx`) is 16 + bits 7:4. LDI writes the constant and leaves every flag unchanged.
- R5: For add, subtract and negate, C is the carry or borrow out of bit 7 and H is the carry or borrow out of bit 3. V is the two's-complement overflow, N is result bit 7, S is N XOR V, and Z is set exactly when the result is zero.
- R6: For SBC, SBCI and CPC, Z is set only when the result is zero and `in_flags` Z was already set.
- R7: CP, CPC and CPI set the flags exactly as the matching subtract does, and `out_wr_en` stays low.
- R8: AND, OR, EOR, ANDI and ORI write the bitwise result, clear V, set N and Z from the result and set S equal to N. C and H are left unchanged.
- R9: Single-operand words have bits 15:9 = 1001010, the register in bits 8:4 and the operation in bits 3:0: COM 0000, NEG 0001, SWAP 0010, INC 0011, ASR 0101, LSR 0110, ROR 0111, DEC 1010, LSL 1011, ROL 1100. COM writes 0xFF-Rd, sets C, clears V and leaves H unchanged. NEG writes 0x00-Rd, sets C unless the result is 0x00, and sets V only when the result is 0x80.
- R10: INC and DEC leave C and H unchanged. V is set only on 0x7F to 0x80 for INC and only on 0x80 to 0x7F for DEC. N, Z and S follow R5.
- R11: Shift and rotate behave as follows. LSR fills bit 7 with 0. ASR keeps bit 7. ROR fills bit 7 with the incoming C. LSL fills bit 0 with 0. ROL fills bit 0 with the incoming C. C takes the bit shifted out, V = N XOR C, S = N XOR V, and H is unchanged.
- R12: SWAP writes Rd with its two nibbles exchanged and leaves every flag unchanged.
- R13: Any word that matches no encoding above keeps `out_wr_en` low and makes `out_flags` equal to `in_flags`. This includes bits 15:10 = 001011 and single-operand code 0100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | An instruction word and its operands are presented |
| in_ready | output | 1 | The block can accept the presented word (follows out_ready) |
| in_insn | input | 16 | Instruction word |
| in_rd | input | 8 | Value of the destination register |
| in_rr | input | 8 | Value of the source register |
| in_flags | input | 8 | Current status byte |
| dst_idx | output | 5 | Destination register index decoded from the word |
| src_idx | output | 5 | Source register index decoded from the word |
| out_valid | output | 1 | Result, write enable and status are valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_result | output | 8 | Operation result |
| out_wr_en | output | 1 | Result is to be written to dst_idx |
| out_flags | output | 8 | Updated status byte |

## Verification
The two functions that fall into the same word are the carry chain of a chained subtract and the zero-flag hold of R6: one SBC, SBCI or CPC word both consumes the incoming C and depends on the incoming Z. The bench provokes this by presenting chained subtracts whose result is zero with Z clear, then with Z set, and by presenting one whose incoming C turns a zero difference into 0xFF while Z is set. Each case is judged against the full expected status byte, worked out from the requirements. A compare word sent while `out_ready` is low is also checked, to confirm that suppressing the write and computing the flags do not disturb each other.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  localparam int BW   = 8;
  localparam int IW   = 16;
  localparam int RIW  = 5;
  localparam int HALF = BW / 2;
  localparam int MSB  = BW - 1;

  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;
  localparam int FL_T = 6;
  localparam int FL_I = 7;

  typedef enum logic [4:0] {
    OP_NONE, OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC,
    OP_AND, OP_OR, OP_EOR, OP_COM, OP_NEG, OP_INC, OP_DEC,
    OP_LSR, OP_ASR, OP_ROR, OP_LSL, OP_ROL, OP_SWAP, OP_LDI
  } alu_op_e;

  typedef struct packed {
    alu_op_e          op;
    logic             use_imm;
    logic [BW-1:0]    imm;
    logic [RIW-1:0]   dst;
    logic [RIW-1:0]   src;
  } dec_t;
endpackage

// File: rtl/byte_alu_decode.sv
module byte_alu_decode
  import byte_alu_pkg::*;
(
  input  logic [IW-1:0] insn,
  output dec_t          dec
);
  always_comb begin
    dec         = '0;
    dec.op      = OP_NONE;
    dec.use_imm = 1'b0;
    dec.imm     = {insn[11:8], insn[3:0]};
    dec.dst     = insn[8:4];
    dec.src     = {insn[9], insn[3:0]};
    if (insn[15:9] == 7'b1001010) begin
      dec.src = insn[8:4];
      case (insn[3:0])
        4'b0000: dec.op = OP_COM;
        4'b0001: dec.op = OP_NEG;
        4'b0010: dec.op = OP_SWAP;
        4'b0011: dec.op = OP_INC;
        4'b0101: dec.op = OP_ASR;
        4'b0110: dec.op = OP_LSR;
        4'b0111: dec.op = OP_ROR;
        4'b1010: dec.op = OP_DEC;
        4'b1011: dec.op = OP_LSL;
        4'b1100: dec.op = OP_ROL;
        default: dec.op = OP_NONE;
      endcase
    end else begin
      case (insn[15:12])
        4'b0011, 4'b0100, 4'b0101, 4'b0110, 4'b0111, 4'b1110: begin
          dec.use_imm = 1'b1;
          dec.dst     = {1'b1, insn[7:4]};
          dec.src     = {1'b1, insn[7:4]};
          case (insn[15:12])
            4'b0011: dec.op = OP_CP;
            4'b0100: dec.op = OP_SBC;
            4'b0101: dec.op = OP_SUB;
            4'b0110: dec.op = OP_OR;
            4'b0111: dec.op = OP_AND;
            default: dec.op = OP_LDI;
          endcase
        end
        default: begin
          case (insn[15:10])
            6'b000001: dec.op = OP_CPC;
            6'b000010: dec.op = OP_SBC;
            6'b000011: dec.op = OP_ADD;
            6'b000101: dec.op = OP_CP;
            6'b000110: dec.op = OP_SUB;
            6'b000111: dec.op = OP_ADC;
            6'b001000: dec.op = OP_AND;
            6'b001001: dec.op = OP_EOR;
            6'b001010: dec.op = OP_OR;
            default:   dec.op = OP_NONE;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/byte_alu_addsub.sv
module byte_alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         co,
  output logic         hc,
  output logic         ov
);
  localparam int HW = W / 2;

  logic [W-1:0] b_eff;
  logic [W:0]   c;

  assign b_eff = sub ? ~b : b;
  assign c[0]  = sub ? ~cin : cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]   = a[i] ^ b_eff[i] ^ c[i];
    assign c[i + 1] = (a[i] & b_eff[i]) | (a[i] & c[i]) | (b_eff[i] & c[i]);
  end

  assign co = sub ? ~c[W]  : c[W];
  assign hc = sub ? ~c[HW] : c[HW];
  assign ov = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
endmodule

// File: rtl/byte_alu_bitops.sv
module byte_alu_bitops
  import byte_alu_pkg::*;
(
  input  alu_op_e        op,
  input  logic [BW-1:0]  a,
  input  logic [BW-1:0]  b,
  input  logic           cin,
  output logic [BW-1:0]  res,
  output logic           sout
);
  logic [BW-1:0] swapped;

  for (genvar i = 0; i < HALF; i++) begin : g_swap
    assign swapped[i]        = a[i + HALF];
    assign swapped[i + HALF] = a[i];
  end

  always_comb begin
    res  = a;
    sout = 1'b0;
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_EOR:  res = a ^ b;
      OP_COM:  res = ~a;
      OP_LSR:  begin res = {1'b0, a[MSB:1]};  sout = a[0];   end
      OP_ASR:  begin res = {a[MSB], a[MSB:1]}; sout = a[0];  end
      OP_ROR:  begin res = {cin, a[MSB:1]};   sout = a[0];   end
      OP_LSL:  begin res = {a[MSB-1:0], 1'b0}; sout = a[MSB]; end
      OP_ROL:  begin res = {a[MSB-1:0], cin};  sout = a[MSB]; end
      OP_SWAP: res = swapped;
      OP_LDI:  res = b;
      default: res = a;
    endcase
  end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
(
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [IW-1:0]   in_insn,
  input  logic [BW-1:0]   in_rd,
  input  logic [BW-1:0]   in_rr,
  input  logic [BW-1:0]   in_flags,
  output logic [RIW-1:0]  dst_idx,
  output logic [RIW-1:0]  src_idx,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [BW-1:0]   out_result,
  output logic            out_wr_en,
  output logic [BW-1:0]   out_flags
);
  localparam logic [BW-1:0] ONE = BW'(1);

  dec_t          dec;
  logic [BW-1:0] opb, ar_a, ar_b, ar_sum, bo_res, res;
  logic          ar_sub, ar_cin, ar_co, ar_hc, ar_ov, bo_out, wr;
  logic          chain, res_n;
  logic [BW-1:0] fl;

  byte_alu_decode u_dec (.insn(in_insn), .dec(dec));

  always_comb begin
    opb    = dec.use_imm ? dec.imm : in_rr;
    ar_a   = in_rd;
    ar_b   = opb;
    ar_sub = 1'b0;
    ar_cin = 1'b0;
    case (dec.op)
      OP_ADC:         ar_cin = in_flags[FL_C];
      OP_SUB, OP_CP:  ar_sub = 1'b1;
      OP_SBC, OP_CPC: begin ar_sub = 1'b1; ar_cin = in_flags[FL_C]; end
      OP_NEG:         begin ar_a = '0; ar_b = in_rd; ar_sub = 1'b1; end
      OP_INC:         ar_b = ONE;
      OP_DEC:         begin ar_b = ONE; ar_sub = 1'b1; end
      default:        ar_cin = 1'b0;
    endcase
  end

  byte_alu_addsub #(.W(BW)) u_addsub (
    .a(ar_a), .b(ar_b), .sub(ar_sub), .cin(ar_cin),
    .sum(ar_sum), .co(ar_co), .hc(ar_hc), .ov(ar_ov)
  );

  byte_alu_bitops u_bitops (
    .op(dec.op), .a(in_rd), .b(opb), .cin(in_flags[FL_C]),
    .res(bo_res), .sout(bo_out)
  );

  assign chain = (dec.op == OP_SBC) || (dec.op == OP_CPC);

  always_comb begin
    fl    = in_flags;
    res   = bo_res;
    wr    = 1'b0;
    res_n = 1'b0;
    case (dec.op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
        res      = ar_sum;
        wr       = (dec.op != OP_CP) && (dec.op != OP_CPC);
        res_n    = ar_sum[MSB];
        fl[FL_C] = ar_co;
        fl[FL_H] = ar_hc;
        fl[FL_V] = ar_ov;
        fl[FL_N] = res_n;
        fl[FL_Z] = (ar_sum == '0) && (!chain || in_flags[FL_Z]);
        fl[FL_S] = res_n ^ ar_ov;
      end
      OP_INC, OP_DEC: begin
        res      = ar_sum;
        wr       = 1'b1;
        res_n    = ar_sum[MSB];
        fl[FL_V] = ar_ov;
        fl[FL_N] = res_n;
        fl[FL_Z] = (ar_sum == '0);
        fl[FL_S] = res_n ^ ar_ov;
      end
      OP_AND, OP_OR, OP_EOR, OP_COM: begin
        wr       = 1'b1;
        res_n    = bo_res[MSB];
        fl[FL_V] = 1'b0;
        fl[FL_N] = res_n;
        fl[FL_Z] = (bo_res == '0);
        fl[FL_S] = res_n;
        if (dec.op == OP_COM) fl[FL_C] = 1'b1;
      end
      OP_LSR, OP_ASR, OP_ROR, OP_LSL, OP_ROL: begin
        wr       = 1'b1;
        res_n    = bo_res[MSB];
        fl[FL_C] = bo_out;
        fl[FL_N] = res_n;
        fl[FL_Z] = (bo_res == '0);
        fl[FL_V] = res_n ^ bo_out;
        fl[FL_S] = res_n ^ (res_n ^ bo_out);
      end
      OP_SWAP, OP_LDI: wr = 1'b1;
      default:         wr = 1'b0;
    endcase
  end

  assign in_ready   = out_ready;
  assign out_valid  = in_valid;
  assign out_wr_en  = in_valid & wr;
  assign out_result = res;
  assign out_flags  = fl;
  assign dst_idx    = dec.dst;
  assign src_idx    = dec.src;
endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk (
  input logic        in_valid,
  input logic        in_ready,
  input logic [15:0] in_insn,
  input logic [7:0]  in_flags,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_result,
  input logic        out_wr_en,
  input logic [7:0]  out_flags
);
  logic is_cmp, is_chain, changed;

  assign is_cmp   = (in_insn[15:10] == 6'b000101) || (in_insn[15:10] == 6'b000001) ||
                    (in_insn[15:12] == 4'b0011);
  assign is_chain = (in_insn[15:10] == 6'b000010) || (in_insn[15:10] == 6'b000001) ||
                    (in_insn[15:12] == 4'b0100);
  assign changed  = (out_flags != in_flags);

  always_comb begin
    a_r1_stream_pass: assert ((out_valid == in_valid) && (in_ready == out_ready))
      else $error("stream pass-through broken");
    a_r1_wr_needs_valid: assert (!out_wr_en || out_valid)
      else $error("write enable without valid");
    a_r2_t_i_kept: assert (out_flags[7:6] == in_flags[7:6])
      else $error("T or I altered");
    if (changed) begin
      a_r5_sign_is_n_xor_v: assert (out_flags[4] == (out_flags[2] ^ out_flags[3]))
        else $error("S differs from N xor V");
    end
    if (changed && out_wr_en) begin
      a_r5_n_is_msb: assert (out_flags[2] == out_result[7])
        else $error("N differs from result msb");
    end
    if (is_cmp) begin
      a_r7_cmp_no_write: assert (!out_wr_en)
        else $error("compare wrote a result");
    end
    if (is_chain && !in_flags[1]) begin
      a_r6_zero_held_clear: assert (!out_flags[1])
        else $error("chained subtract set Z from clear");
    end
    if (in_insn[15:10] == 6'b001011) begin
      a_r13_unknown_inert: assert (!out_wr_en && !changed)
        else $error("unrecognised word had an effect");
    end
  end
endmodule

bind byte_alu byte_alu_chk u_chk (
  .in_valid(in_valid), .in_ready(in_ready), .in_insn(in_insn), .in_flags(in_flags),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
  .out_wr_en(out_wr_en), .out_flags(out_flags)
);

// File: tb/test_byte_alu.sv
`timescale 1ns/1ps
module test_byte_alu;
  logic        clk = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b1;
  logic        in_ready, out_valid, out_wr_en;
  logic [15:0] in_insn = '0;
  logic [7:0]  in_rd = '0, in_rr = '0, in_flags = '0;
  logic [4:0]  dst_idx, src_idx;
  logic [7:0]  out_result, out_flags;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  byte_alu i_byte_alu (
    .in_valid(in_valid), .in_ready(in_ready), .in_insn(in_insn), .in_rd(in_rd),
    .in_rr(in_rr), .in_flags(in_flags), .dst_idx(dst_idx), .src_idx(src_idx),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_wr_en(out_wr_en), .out_flags(out_flags)
  );

  function automatic logic [15:0] w_rr(input logic [5:0] op6, input logic [4:0] d, input logic [4:0] r);
    return {op6, r[4], d, r[3:0]};
  endfunction
  function automatic logic [15:0] w_imm(input logic [3:0] p, input logic [3:0] d, input logic [7:0] k);
    return {p, k[7:4], d, k[3:0]};
  endfunction
  function automatic logic [15:0] w_one(input logic [4:0] d, input logic [3:0] code);
    return {7'b1001010, d, code};
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %02h expected %02h", tag, what, got, exp);
    end
  endtask

  task automatic run(input string tag, input string nm, input logic [15:0] w, input logic [7:0] rd,
                     input logic [7:0] rr, input logic [7:0] fin, input logic exp_wr,
                     input logic [7:0] exp_res, input logic [7:0] exp_fl);
    @(negedge clk);
    in_valid = 1'b1; in_insn = w; in_rd = rd; in_rr = rr; in_flags = fin;
    #2;
    chk(tag, {nm, " wr_en"}, {7'b0, out_wr_en}, {7'b0, exp_wr});
    if (exp_wr) chk(tag, {nm, " result"}, out_result, exp_res);
    chk(tag, {nm, " flags"}, out_flags, exp_fl);
  endtask

  task automatic t_stream;
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0; in_insn = w_rr(6'b000011, 5'd1, 5'd2);
    #2;
    chk("R1", "idle out_valid", {7'b0, out_valid}, 8'h00);
    chk("R1", "idle wr_en", {7'b0, out_wr_en}, 8'h00);
    chk("R1", "stalled in_ready", {7'b0, in_ready}, 8'h00);
    @(negedge clk);
    out_ready = 1'b1;
    #2;
    chk("R1", "open in_ready", {7'b0, in_ready}, 8'h01);
    @(negedge clk);
    in_valid = 1'b1;
    #2;
    chk("R1", "busy out_valid", {7'b0, out_valid}, 8'h01);
    // R7 compare while stalled: no write, flags still computed
    @(negedge clk);
    out_ready = 1'b0;
    in_insn = w_rr(6'b000101, 5'd4, 5'd5); in_rd = 8'h80; in_rr = 8'h01; in_flags = 8'h00;
    #2;
    chk("R7", "stalled cp wr_en", {7'b0, out_wr_en}, 8'h00);
    chk("R7", "stalled cp flags", out_flags, 8'h38);
    chk("R1", "stalled in_ready", {7'b0, in_ready}, 8'h00);
    @(negedge clk);
    out_ready = 1'b1;
  endtask

  task automatic t_addsub;
    run("R5", "add 3a+46", w_rr(6'b000011, 5'd3, 5'd17), 8'h3A, 8'h46, 8'hC0, 1'b1, 8'h80, 8'hEC);
    chk("R3", "add dst_idx", {3'b0, dst_idx}, 8'd3);
    chk("R3", "add src_idx", {3'b0, src_idx}, 8'd17);
    chk("R2", "T and I kept", {out_flags[7:6], 6'b0}, 8'hC0);
    run("R3", "adc ff+00+c", w_rr(6'b000111, 5'd0, 5'd1), 8'hFF, 8'h00, 8'h01, 1'b1, 8'h00, 8'h23);
    run("R3", "sub 10-01", w_rr(6'b000110, 5'd2, 5'd3), 8'h10, 8'h01, 8'h00, 1'b1, 8'h0F, 8'h20);
  endtask

  task automatic t_chain;
    run("R6", "sbc zero, z clear", w_rr(6'b000010, 5'd6, 5'd7), 8'h05, 8'h05, 8'h00, 1'b1, 8'h00, 8'h00);
    run("R6", "sbc zero, z set", w_rr(6'b000010, 5'd6, 5'd7), 8'h05, 8'h05, 8'h02, 1'b1, 8'h00, 8'h02);
    run("R6", "sbc 00-00-c", w_rr(6'b000010, 5'd6, 5'd7), 8'h00, 8'h00, 8'h03, 1'b1, 8'hFF, 8'h35);
    run("R6", "sbci 10-0f-c", w_imm(4'b0100, 4'd2, 8'h0F), 8'h10, 8'h00, 8'h03, 1'b1, 8'h00, 8'h22);
  endtask

  task automatic t_compare;
    run("R7", "cp 80-01", w_rr(6'b000101, 5'd8, 5'd9), 8'h80, 8'h01, 8'h00, 1'b0, 8'h00, 8'h38);
    run("R7", "cpc 01-01-c", w_rr(6'b000001, 5'd8, 5'd9), 8'h01, 8'h01, 8'h03, 1'b0, 8'h00, 8'h35);
    run("R7", "cpi equal", w_imm(4'b0011, 4'd5, 8'h40), 8'h40, 8'h00, 8'h00, 1'b0, 8'h00, 8'h02);
  endtask

  task automatic t_imm;
    run("R4", "subi 00-01", w_imm(4'b0101, 4'd15, 8'h01), 8'h00, 8'h77, 8'h00, 1'b1, 8'hFF, 8'h35);
    chk("R4", "subi dst_idx", {3'b0, dst_idx}, 8'd31);
    run("R4", "ldi a5", w_imm(4'b1110, 4'd0, 8'hA5), 8'h12, 8'h34, 8'h3F, 1'b1, 8'hA5, 8'h3F);
    chk("R4", "ldi dst_idx", {3'b0, dst_idx}, 8'd16);
  endtask

  task automatic t_logic;
    run("R8", "and f0&8f", w_rr(6'b001000, 5'd1, 5'd2), 8'hF0, 8'h8F, 8'h29, 1'b1, 8'h80, 8'h35);
    run("R8", "or zero", w_rr(6'b001010, 5'd1, 5'd2), 8'h00, 8'h00, 8'h08, 1'b1, 8'h00, 8'h02);
    run("R8", "eor 55^ff", w_rr(6'b001001, 5'd1, 5'd2), 8'h55, 8'hFF, 8'h21, 1'b1, 8'hAA, 8'h35);
    run("R8", "andi 3c&0f", w_imm(4'b0111, 4'd1, 8'h0F), 8'h3C, 8'h00, 8'h00, 1'b1, 8'h0C, 8'h00);
    run("R8", "ori 01|80", w_imm(4'b0110, 4'd1, 8'h80), 8'h01, 8'h00, 8'h00, 1'b1, 8'h81, 8'h14);
  endtask

  task automatic t_single;
    run("R9", "com 5a", w_one(5'd9, 4'b0000), 8'h5A, 8'h00, 8'h20, 1'b1, 8'hA5, 8'h35);
    run("R9", "com ff", w_one(5'd9, 4'b0000), 8'hFF, 8'h00, 8'h00, 1'b1, 8'h00, 8'h03);
    run("R9", "neg 80", w_one(5'd9, 4'b0001), 8'h80, 8'h00, 8'h00, 1'b1, 8'h80, 8'h0D);
    run("R9", "neg 00", w_one(5'd9, 4'b0001), 8'h00, 8'h00, 8'h01, 1'b1, 8'h00, 8'h02);
    run("R9", "neg 01", w_one(5'd9, 4'b0001), 8'h01, 8'h00, 8'h00, 1'b1, 8'hFF, 8'h35);
  endtask

  task automatic t_incdec;
    run("R10", "inc 7f", w_one(5'd20, 4'b0011), 8'h7F, 8'h00, 8'h21, 1'b1, 8'h80, 8'h2D);
    chk("R10", "inc dst_idx", {3'b0, dst_idx}, 8'd20);
    run("R10", "inc ff", w_one(5'd20, 4'b0011), 8'hFF, 8'h00, 8'h00, 1'b1, 8'h00, 8'h02);
    run("R10", "dec 80", w_one(5'd20, 4'b1010), 8'h80, 8'h00, 8'h01, 1'b1, 8'h7F, 8'h19);
    run("R10", "dec 01", w_one(5'd20, 4'b1010), 8'h01, 8'h00, 8'h00, 1'b1, 8'h00, 8'h02);
  endtask

  task automatic t_shift;
    run("R11", "lsr 81", w_one(5'd3, 4'b0110), 8'h81, 8'h00, 8'h20, 1'b1, 8'h40, 8'h39);
    run("R11", "asr 81", w_one(5'd3, 4'b0101), 8'h81, 8'h00, 8'h00, 1'b1, 8'hC0, 8'h15);
    run("R11", "ror 02 c", w_one(5'd3, 4'b0111), 8'h02, 8'h00, 8'h01, 1'b1, 8'h81, 8'h0C);
    run("R11", "lsl 80", w_one(5'd3, 4'b1011), 8'h80, 8'h00, 8'h00, 1'b1, 8'h00, 8'h1B);
    run("R11", "rol 40 c", w_one(5'd3, 4'b1100), 8'h40, 8'h00, 8'h01, 1'b1, 8'h81, 8'h0C);
  endtask

  task automatic t_swap;
    run("R12", "swap 3c", w_one(5'd11, 4'b0010), 8'h3C, 8'h00, 8'hA5, 1'b1, 8'hC3, 8'hA5);
  endtask

  task automatic t_unknown;
    run("R13", "word 001011", w_rr(6'b001011, 5'd1, 5'd2), 8'h12, 8'h34, 8'h5A, 1'b0, 8'h00, 8'h5A);
    run("R13", "single code 0100", w_one(5'd1, 4'b0100), 8'h80, 8'h00, 8'h3C, 1'b0, 8'h00, 8'h3C);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    t_stream();
    t_addsub();
    t_chain();
    t_compare();
    t_imm();
    t_logic();
    t_single();
    t_incdec();
    t_shift();
    t_swap();
    t_unknown();
    @(negedge clk);
    in_valid = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule